// File: doc/BRIEF.md
# Microcoded Control Sequencer for a Multicycle Datapath

This block is the control unit of a multicycle processor datapath that handles word loads, word stores, register-register arithmetic, branch-on-equal and unconditional jumps. It does not use a hand-built state machine. It steps through a small microprogram held in a read-only control store. Each microword is split into seven fields: ALU operation, first operand source, second operand source, register-file action, memory action, program-counter update and sequencing. The control lines that drive the datapath are decoded from the fields of the microword that is current.

The sequencing field of the current microword picks the next micro-address. It has four choices: step to the following word, go back to the common fetch word at address zero, or jump through one of two opcode-indexed dispatch tables. The first dispatch table splits the instructions into their families after decode. The second table separates loads from stores after the address has been computed. An opcode that a table does not list leads back to fetch. The control store is read synchronously, so the microword register also serves as the registered output stage. Cycle by cycle, the control lines equal those of the classic hardwired multicycle controller.

Top module: `useq_ctrl`

## Requirements
- R1: While `rst` is high, every rising edge loads micro-address 0 (fetch). In the first cycle after `rst` falls, `upc_o` is 0 and the outputs carry the fetch controls.
- R2: At micro-address 0, `mem_re_o`, `ir_load_o` and `pc_load_o` are 1, `opnd_b_sel_o` is 01 (constant four), and `opnd_a_sel_o`, `alu_mode_o`, `pc_next_sel_o` and `mem_addr_sel_o` are 0. The next micro-address is always 1.
- R3: At micro-address 1, `opnd_b_sel_o` is 11 (shifted offset) and every write enable is 0. The next address comes from the first dispatch table, using the opcode sampled at the end of this cycle: 100011 and 101011 go to 2, 000000 goes to 6, 000100 goes to 8, and 000010 goes to 9.
- R4: At micro-address 2, `opnd_a_sel_o` is 1 and `opnd_b_sel_o` is 10. The second dispatch table, using the opcode sampled at the end of this cycle, sends 100011 to 3 and 101011 to 5.
- R5: A load takes addresses 0,1,2,3,4 and then returns to 0. At 3, `mem_re_o` and `mem_addr_sel_o` are 1. At 4, `rf_we_o` and `wb_from_mem_o` are 1 and `wb_dst_rd_o` is 0.
- R6: A store takes addresses 0,1,2,5 and then returns to 0. At 5, `mem_we_o` and `mem_addr_sel_o` are 1.
- R7: A register-register instruction takes addresses 0,1,6,7 and then returns to 0. At 6, `alu_mode_o` is 10, `opnd_a_sel_o` is 1 and `opnd_b_sel_o` is 00. At 7, `rf_we_o` and `wb_dst_rd_o` are 1 and `wb_from_mem_o` is 0.
- R8: A branch takes addresses 0,1,8 and then returns to 0. At 8, `alu_mode_o` is 01, `opnd_a_sel_o` is 1, `pc_load_br_o` is 1 and `pc_next_sel_o` is 01.
- R9: A jump takes addresses 0,1,9 and then returns to 0. At 9, `pc_load_o` is 1 and `pc_next_sel_o` is 10.
- R10: An opcode that the first dispatch table does not list sends the sequencer from address 1 straight back to 0.
- R11: `upc_o` stays inside the occupied microprogram, 0 to 9.
- R12: An opcode other than 100011 or 101011 at the second dispatch point sends the sequencer from address 2 back to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode_i | input | 6 | Opcode field of the instruction register |
| upc_o | output | 4 | Current micro-address |
| pc_load_o | output | 1 | Unconditional program-counter write |
| pc_load_br_o | output | 1 | Program-counter write qualified by the ALU zero flag |
| pc_next_sel_o | output | 2 | PC source: 00 ALU result, 01 ALU output register, 10 jump target |
| mem_addr_sel_o | output | 1 | Memory address from ALU output register (1) or PC (0) |
| mem_re_o | output | 1 | Memory read |
| mem_we_o | output | 1 | Memory write |
| ir_load_o | output | 1 | Instruction register load |
| wb_from_mem_o | output | 1 | Register write data from memory data register |
| rf_we_o | output | 1 | Register file write |
| wb_dst_rd_o | output | 1 | Destination register from rd field (1) or rt field (0) |
| opnd_a_sel_o | output | 1 | ALU operand A: register A (1) or PC (0) |
| opnd_b_sel_o | output | 2 | ALU operand B: 00 register B, 01 four, 10 offset, 11 shifted offset |
| alu_mode_o | output | 2 | ALU operation: 00 add, 01 subtract, 10 function field |

## Verification
The control store is read with a registered access. The microword chosen at a rising edge therefore appears on every output and on `upc_o` during the cycle that follows that edge, and no output changes within a cycle. The bench works from the instruction in hand and the opcode held at each dispatch edge. From these it predicts the complete list of micro-addresses and control vectors, one entry per cycle, starting at decode and ending at the return to fetch. A monitor compares one entry at every falling edge, which is half a cycle after the edge that produced it. The opcode is changed only just after the edge into address 2, so the first and second dispatch decisions can be tested independently.

// File: rtl/useq_pkg.sv
package useq_pkg;

  // Field encodings of one microword
  typedef enum logic [1:0] {ALU_ADD = 2'd0, ALU_SUB = 2'd1, ALU_FUNC = 2'd2, ALU_RSV = 2'd3} alu_f_e;
  typedef enum logic       {S1_PC = 1'b0, S1_REGA = 1'b1} src1_f_e;
  typedef enum logic [1:0] {S2_REGB = 2'd0, S2_FOUR = 2'd1, S2_EXT = 2'd2, S2_EXTSH = 2'd3} src2_f_e;
  typedef enum logic [1:0] {RG_NONE = 2'd0, RG_READ = 2'd1, RG_WR_ALU = 2'd2, RG_WR_MDR = 2'd3} reg_f_e;
  typedef enum logic [1:0] {MM_NONE = 2'd0, MM_RD_PC = 2'd1, MM_RD_ALU = 2'd2, MM_WR_ALU = 2'd3} mem_f_e;
  typedef enum logic [1:0] {PW_NONE = 2'd0, PW_ALU = 2'd1, PW_COND = 2'd2, PW_JUMP = 2'd3} pcw_f_e;
  typedef enum logic [1:0] {SQ_NEXT = 2'd0, SQ_FETCH = 2'd1, SQ_DISP1 = 2'd2, SQ_DISP2 = 2'd3} seq_f_e;

  typedef struct packed {
    alu_f_e  alu;
    src1_f_e s1;
    src2_f_e s2;
    reg_f_e  rg;
    mem_f_e  mm;
    pcw_f_e  pw;
    seq_f_e  sq;
  } uword_t;

  // Decoded datapath control lines
  typedef struct packed {
    logic       pc_load;
    logic       pc_load_br;
    logic [1:0] pc_next_sel;
    logic       mem_addr_sel;
    logic       mem_re;
    logic       mem_we;
    logic       ir_load;
    logic       wb_from_mem;
    logic       rf_we;
    logic       wb_dst_rd;
    logic       opnd_a_sel;
    logic [1:0] opnd_b_sel;
    logic [1:0] alu_mode;
  } ctrl_t;

  // Microprogram labels (addresses); order fixes the sequential steps
  localparam int LBL_FETCH  = 0;
  localparam int LBL_DECODE = 1;
  localparam int LBL_MEM1   = 2;
  localparam int LBL_LD2    = 3;
  localparam int LBL_LDWB   = 4;
  localparam int LBL_ST2    = 5;
  localparam int LBL_RR1    = 6;
  localparam int LBL_RRWB   = 7;
  localparam int LBL_BR1    = 8;
  localparam int LBL_JMP1   = 9;
  localparam int LBL_COUNT  = 10;

  // Opcodes understood by the dispatch tables
  localparam logic [5:0] OPC_RR  = 6'b000000;
  localparam logic [5:0] OPC_LD  = 6'b100011;
  localparam logic [5:0] OPC_ST  = 6'b101011;
  localparam logic [5:0] OPC_BR  = 6'b000100;
  localparam logic [5:0] OPC_JMP = 6'b000010;

  // Content of the control store at a given address
  function automatic uword_t ucode_word(input int addr);
    uword_t w;
    w = '0;
    w.sq = SQ_FETCH;
    case (addr)
      LBL_FETCH: begin
        w.s2 = S2_FOUR; w.mm = MM_RD_PC; w.pw = PW_ALU; w.sq = SQ_NEXT;
      end
      LBL_DECODE: begin
        w.s2 = S2_EXTSH; w.rg = RG_READ; w.sq = SQ_DISP1;
      end
      LBL_MEM1: begin
        w.s1 = S1_REGA; w.s2 = S2_EXT; w.sq = SQ_DISP2;
      end
      LBL_LD2: begin
        w.mm = MM_RD_ALU; w.sq = SQ_NEXT;
      end
      LBL_LDWB:  w.rg = RG_WR_MDR;
      LBL_ST2:   w.mm = MM_WR_ALU;
      LBL_RR1: begin
        w.alu = ALU_FUNC; w.s1 = S1_REGA; w.s2 = S2_REGB; w.sq = SQ_NEXT;
      end
      LBL_RRWB:  w.rg = RG_WR_ALU;
      LBL_BR1: begin
        w.alu = ALU_SUB; w.s1 = S1_REGA; w.s2 = S2_REGB; w.pw = PW_COND;
      end
      LBL_JMP1:  w.pw = PW_JUMP;
      default:   w.sq = SQ_FETCH;
    endcase
    return w;
  endfunction

  // Dispatch after decode; unlisted opcodes fall back to fetch
  function automatic int disp1_label(input int op);
    if (op == int'(OPC_LD) || op == int'(OPC_ST)) return LBL_MEM1;
    if (op == int'(OPC_RR))  return LBL_RR1;
    if (op == int'(OPC_BR))  return LBL_BR1;
    if (op == int'(OPC_JMP)) return LBL_JMP1;
    return LBL_FETCH;
  endfunction

  // Dispatch after address computation
  function automatic int disp2_label(input int op);
    if (op == int'(OPC_LD)) return LBL_LD2;
    if (op == int'(OPC_ST)) return LBL_ST2;
    return LBL_FETCH;
  endfunction

endpackage

// File: rtl/useq_rom.sv
module useq_rom
  import useq_pkg::*;
#(
  parameter int UPC_W = 4
) (
  input  logic             clk,
  input  logic [UPC_W-1:0] rd_addr,
  output uword_t           rd_word
);
  localparam int DEPTH = 1 << UPC_W;

  uword_t store [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) store[i] = ucode_word(i);
  end

  // Registered read: the output register holds the current microword
  always_ff @(posedge clk) begin
    rd_word <= store[rd_addr];
  end
endmodule

// File: rtl/useq_dispatch.sv
module useq_dispatch
  import useq_pkg::*;
#(
  parameter int OPC_W     = 6,
  parameter int UPC_W     = 4,
  parameter int TABLE_SEL = 1
) (
  input  logic [OPC_W-1:0] opcode,
  output logic [UPC_W-1:0] target
);
  localparam int ENTRIES = 1 << OPC_W;

  logic [UPC_W-1:0] table_q [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    localparam int LBL = (TABLE_SEL == 1) ? disp1_label(i) : disp2_label(i);
    assign table_q[i] = UPC_W'(LBL);
  end

  assign target = table_q[opcode];
endmodule

// File: rtl/useq_next.sv
module useq_next
  import useq_pkg::*;
#(
  parameter int UPC_W = 4
) (
  input  logic             rst,
  input  seq_f_e           seq,
  input  logic [UPC_W-1:0] upc,
  input  logic [UPC_W-1:0] disp1_tgt,
  input  logic [UPC_W-1:0] disp2_tgt,
  output logic [UPC_W-1:0] nxt
);
  always_comb begin
    if (rst) begin
      nxt = '0;
    end else begin
      case (seq)
        SQ_NEXT:  nxt = upc + UPC_W'(1);
        SQ_DISP1: nxt = disp1_tgt;
        SQ_DISP2: nxt = disp2_tgt;
        default:  nxt = '0;
      endcase
    end
  end
endmodule

// File: rtl/useq_decode.sv
module useq_decode
  import useq_pkg::*;
(
  input  uword_t uw,
  output ctrl_t  ctl
);
  always_comb begin
    ctl              = '0;
    ctl.alu_mode     = uw.alu;
    ctl.opnd_a_sel   = uw.s1;
    ctl.opnd_b_sel   = uw.s2;
    ctl.rf_we        = (uw.rg == RG_WR_ALU) || (uw.rg == RG_WR_MDR);
    ctl.wb_from_mem  = (uw.rg == RG_WR_MDR);
    ctl.wb_dst_rd    = (uw.rg == RG_WR_ALU);
    ctl.mem_re       = (uw.mm == MM_RD_PC) || (uw.mm == MM_RD_ALU);
    ctl.mem_we       = (uw.mm == MM_WR_ALU);
    ctl.ir_load      = (uw.mm == MM_RD_PC);
    ctl.mem_addr_sel = (uw.mm == MM_RD_ALU) || (uw.mm == MM_WR_ALU);
    ctl.pc_load      = (uw.pw == PW_ALU) || (uw.pw == PW_JUMP);
    ctl.pc_load_br   = (uw.pw == PW_COND);
    case (uw.pw)
      PW_COND: ctl.pc_next_sel = 2'b01;
      PW_JUMP: ctl.pc_next_sel = 2'b10;
      default: ctl.pc_next_sel = 2'b00;
    endcase
  end
endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
  import useq_pkg::*;
#(
  parameter int OPC_W = 6,
  parameter int UPC_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opcode_i,
  output logic [UPC_W-1:0] upc_o,
  output logic             pc_load_o,
  output logic             pc_load_br_o,
  output logic [1:0]       pc_next_sel_o,
  output logic             mem_addr_sel_o,
  output logic             mem_re_o,
  output logic             mem_we_o,
  output logic             ir_load_o,
  output logic             wb_from_mem_o,
  output logic             rf_we_o,
  output logic             wb_dst_rd_o,
  output logic             opnd_a_sel_o,
  output logic [1:0]       opnd_b_sel_o,
  output logic [1:0]       alu_mode_o
);
  logic [UPC_W-1:0] upc_q;
  logic [UPC_W-1:0] nxt;
  logic [UPC_W-1:0] d1_tgt;
  logic [UPC_W-1:0] d2_tgt;
  uword_t           uw_q;
  ctrl_t            ctl;

  useq_dispatch #(.OPC_W(OPC_W), .UPC_W(UPC_W), .TABLE_SEL(1)) u_disp1 (
    .opcode (opcode_i),
    .target (d1_tgt)
  );

  useq_dispatch #(.OPC_W(OPC_W), .UPC_W(UPC_W), .TABLE_SEL(2)) u_disp2 (
    .opcode (opcode_i),
    .target (d2_tgt)
  );

  useq_next #(.UPC_W(UPC_W)) u_next (
    .rst       (rst),
    .seq       (uw_q.sq),
    .upc       (upc_q),
    .disp1_tgt (d1_tgt),
    .disp2_tgt (d2_tgt),
    .nxt       (nxt)
  );

  useq_rom #(.UPC_W(UPC_W)) u_rom (
    .clk     (clk),
    .rd_addr (nxt),
    .rd_word (uw_q)
  );

  // Micro-PC tracks the address whose word sits in the ROM output register
  always_ff @(posedge clk) begin
    if (rst) upc_q <= '0;
    else     upc_q <= nxt;
  end

  useq_decode u_dec (
    .uw  (uw_q),
    .ctl (ctl)
  );

  assign upc_o          = upc_q;
  assign pc_load_o      = ctl.pc_load;
  assign pc_load_br_o   = ctl.pc_load_br;
  assign pc_next_sel_o  = ctl.pc_next_sel;
  assign mem_addr_sel_o = ctl.mem_addr_sel;
  assign mem_re_o       = ctl.mem_re;
  assign mem_we_o       = ctl.mem_we;
  assign ir_load_o      = ctl.ir_load;
  assign wb_from_mem_o  = ctl.wb_from_mem;
  assign rf_we_o        = ctl.rf_we;
  assign wb_dst_rd_o    = ctl.wb_dst_rd;
  assign opnd_a_sel_o   = ctl.opnd_a_sel;
  assign opnd_b_sel_o   = ctl.opnd_b_sel;
  assign alu_mode_o     = ctl.alu_mode;

  AST_FETCH_THEN_DECODE: assert property (@(posedge clk) disable iff (rst)
    (upc_q == '0) |=> (upc_q == UPC_W'(LBL_DECODE))); // R2
  AST_DISP1_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (upc_q == UPC_W'(LBL_DECODE)) |=> (upc_q == '0 || upc_q == UPC_W'(LBL_MEM1) ||
      upc_q == UPC_W'(LBL_RR1) || upc_q == UPC_W'(LBL_BR1) || upc_q == UPC_W'(LBL_JMP1))); // R3
  AST_DISP2_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (upc_q == UPC_W'(LBL_MEM1)) |=> (upc_q == '0 || upc_q == UPC_W'(LBL_LD2) ||
      upc_q == UPC_W'(LBL_ST2))); // R4
  AST_LOAD_WRITEBACK: assert property (@(posedge clk) disable iff (rst)
    (upc_q == UPC_W'(LBL_LD2)) |=> (rf_we_o && wb_from_mem_o)); // R5
  AST_WRITE_ENDS_INSTR: assert property (@(posedge clk) disable iff (rst)
    (rf_we_o || mem_we_o || pc_load_br_o) |=> (upc_q == '0)); // R6
  AST_UPC_RANGE: assert property (@(posedge clk) disable iff (rst)
    (upc_q < UPC_W'(LBL_COUNT))); // R11
endmodule

// File: tb/useq_ctrl_bench.sv
`timescale 1ns/1ps
module useq_ctrl_bench;
  localparam logic [5:0] B_RR  = 6'b000000;
  localparam logic [5:0] B_LD  = 6'b100011;
  localparam logic [5:0] B_ST  = 6'b101011;
  localparam logic [5:0] B_BR  = 6'b000100;
  localparam logic [5:0] B_JMP = 6'b000010;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = 6'b000000;
  logic [3:0] upc;
  logic       pcl, pcb, mas, mre, mwe, irl, wbm, rfw, wbd, osa;
  logic [1:0] pns, osb, alm;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  mon_en  = 1'b0;
  bit  done    = 1'b0;

  logic [19:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  useq_ctrl u_useq_ctrl (
    .clk(clk), .rst(rst), .opcode_i(opcode), .upc_o(upc),
    .pc_load_o(pcl), .pc_load_br_o(pcb), .pc_next_sel_o(pns),
    .mem_addr_sel_o(mas), .mem_re_o(mre), .mem_we_o(mwe), .ir_load_o(irl),
    .wb_from_mem_o(wbm), .rf_we_o(rfw), .wb_dst_rd_o(wbd),
    .opnd_a_sel_o(osa), .opnd_b_sel_o(osb), .alu_mode_o(alm)
  );

  function automatic logic [19:0] observed();
    return {upc, pcl, pcb, pns, mas, mre, mwe, irl, wbm, rfw, wbd, osa, osb, alm};
  endfunction

  // Expected vector per micro-address, taken from the requirements
  function automatic logic [19:0] exp_word(input int a);
    logic pl = 0, pb = 0, ma = 0, rd = 0, wr = 0, il = 0, wm = 0, rw = 0, wd = 0, sa = 0;
    logic [1:0] ps = 0, sb = 0, am = 0;
    case (a)
      0: begin pl = 1; rd = 1; il = 1; sb = 2'b01; end       // R2
      1: sb = 2'b11;                                           // R3
      2: begin sa = 1; sb = 2'b10; end                         // R4
      3: begin rd = 1; ma = 1; end                             // R5
      4: begin rw = 1; wm = 1; end                             // R5
      5: begin wr = 1; ma = 1; end                             // R6
      6: begin am = 2'b10; sa = 1; end                         // R7
      7: begin rw = 1; wd = 1; end                             // R7
      8: begin am = 2'b01; sa = 1; pb = 1; ps = 2'b01; end     // R8
      9: begin pl = 1; ps = 2'b10; end                         // R9
      default: ;
    endcase
    return {4'(a), pl, pb, ps, ma, rd, wr, il, wm, rw, wd, sa, sb, am};
  endfunction

  function automatic void push(input int a, input string t);
    exp_q.push_back(exp_word(a));
    tag_q.push_back(t);
  endfunction

  // Monitor: one scoreboard entry per cycle, compared mid-cycle
  always @(negedge clk) begin
    if (mon_en) begin
      n_tests++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL scoreboard empty (R2) actual=%h expected=entry", observed());
      end else begin
        logic [19:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (observed() !== e) begin
          n_fail++;
          $display("FAIL %s actual=%h expected=%h", t, observed(), e);
        end
      end
      n_tests++;
      if (!(upc < 4'd10)) begin // R11
        n_fail++;
        $display("FAIL R11 upc actual=%0d expected<10", upc);
      end
    end
  end

  // Driver: called in a fetch cycle whose entry is already queued
  task automatic issue(input logic [5:0] op, input logic [5:0] late, input string t);
    int body[$];
    int n;
    if (op == B_LD || op == B_ST) begin
      body.push_back(2);
      if (late == B_LD) begin body.push_back(3); body.push_back(4); end
      else if (late == B_ST) body.push_back(5);
    end else if (op == B_RR) begin
      body.push_back(6); body.push_back(7);
    end else if (op == B_BR) body.push_back(8);
    else if (op == B_JMP) body.push_back(9);
    opcode = op;
    push(1, "R3 decode");
    foreach (body[i]) push(body[i], t);
    push(0, t);
    n = body.size() + 2;
    for (int k = 1; k <= n; k++) begin
      @(posedge clk); #1;
      if (k == 2) opcode = late;
    end
  endtask

  task automatic check_fetch(input string t);
    n_tests++;
    if (observed() !== exp_word(0)) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", t, observed(), exp_word(0));
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check_fetch("R1 reset state");
    rst = 1'b0;
    push(0, "R1 first fetch");
    mon_en = 1'b1;

    issue(B_LD,  B_LD,  "R5 load");
    issue(B_ST,  B_ST,  "R6 store");
    issue(B_RR,  B_RR,  "R7 reg-reg");
    issue(B_BR,  B_BR,  "R8 branch");
    issue(B_JMP, B_JMP, "R9 jump");
    issue(6'b111111, 6'b111111, "R10 unknown op");
    issue(6'b001000, 6'b001000, "R10 unknown op");
    issue(B_LD,  B_RR,  "R12 bad disp2");
    issue(B_ST,  B_BR,  "R12 bad disp2");
    issue(B_LD,  B_ST,  "R4 disp2 store");
    issue(B_ST,  B_LD,  "R4 disp2 load");

    // Reset in the middle of a load
    @(negedge clk); #1;
    mon_en = 1'b0;
    opcode = B_LD;
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b1;
    @(posedge clk); #1;
    check_fetch("R1 reset mid-instruction");
    rst = 1'b0;
    push(0, "R1 fetch after reset");
    @(negedge clk);
    mon_en = 1'b1;
    @(posedge clk); #1;
    // Re-align: the pushed fetch was for the cycle just checked; restart from fetch
    mon_en = 1'b0;
    exp_q.delete();
    tag_q.delete();
    rst = 1'b1;
    @(posedge clk); #1;
    rst = 1'b0;
    push(0, "R1 fetch after reset");
    mon_en = 1'b1;

    foreach (exp_q[i]) ;
    issue(B_JMP, B_JMP, "R9 jump");
    issue(B_RR,  B_RR,  "R7 reg-reg");
    issue(B_LD,  B_LD,  "R5 load");
    issue(B_BR,  B_BR,  "R8 branch");
    issue(B_ST,  B_ST,  "R6 store");

    @(negedge clk); #1;
    mon_en = 1'b0;
    n_tests++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R2 leftover entries actual=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog (R1) actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule